// File: doc/BRIEF.md
# Operand Wakeup and Oldest-First Issue Buffer

This block holds instructions waiting for one execution unit. A rename stage
writes an operation with two source operands into a free slot. Each operand
arrives either already holding its value or holding a tag, which is the name of
the result that will supply it. Tags are plain identifiers of `TAG_W` bits and
have no relation to slot numbers.

Finished results are announced on a broadcast bus that carries a valid bit, a
tag and a value. Every waiting operand compares its tag with the bus. On a
match it latches the value and becomes ready. A slot whose two operands are
both ready asks to issue. A selector picks one slot per cycle, always the one
allocated earliest, and sends its operation and operand values to the unit.
The slot becomes free again at the clock edge that ends the cycle in which it
issues.

Operand readiness is registered. Because of this, a broadcast can never cause
an issue in the same cycle, and the compare-capture path stays apart from the
select path. A flush input empties every slot at once.

Top module: `rs_wakeup_select`

## Requirements
- R1: After reset is released, no slot is occupied, `full_o` is 0 and `issue_valid_o` is 0.
- R2: A waiting operand latches `bcast_data_i` and becomes ready only when `bcast_valid_i` is 1 and `bcast_tag_i` equals its tag. A broadcast with a different tag, or with `bcast_valid_i` at 0, leaves it waiting. Any `TAG_W`-bit value is a legal tag.
- R3: An instruction allocated with both operands ready appears on the issue outputs in the cycle after its allocation cycle. `issue_op_o`, `issue_src0_o` and `issue_src1_o` carry its operation and operand values.
- R4: A broadcast in cycle t that completes an instruction's operands makes it issue no earlier than cycle t+1. `issue_valid_o` stays 0 in cycle t for that instruction.
- R5: At most one instruction issues per cycle. Among ready instructions, the one allocated earliest issues first, whatever slot it occupies.
- R6: An operand whose tag matches a valid broadcast in the same cycle it is allocated captures that value on entry.
- R7: An issued instruction's slot is free from the next cycle on. The instruction is not issued again, and a new allocation may reuse the slot.
- R8: `full_o` is 1 exactly when every slot is occupied. While `full_o` is 1, `alloc_valid_i` is ignored and no existing instruction is overwritten.
- R9: While `flush_i` is 1, `issue_valid_o` is 0 and any allocation is dropped. From the next cycle on, all slots are empty and later broadcasts wake nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all slots |
| alloc_valid_i | input | 1 | Allocation request from rename |
| alloc_op_i | input | OP_W | Operation code |
| alloc_src0_rdy_i | input | 1 | Operand 0 already holds its value |
| alloc_src0_tag_i | input | TAG_W | Producer tag of operand 0 |
| alloc_src0_data_i | input | DATA_W | Value of operand 0 when ready |
| alloc_src1_rdy_i | input | 1 | Operand 1 already holds its value |
| alloc_src1_tag_i | input | TAG_W | Producer tag of operand 1 |
| alloc_src1_data_i | input | DATA_W | Value of operand 1 when ready |
| full_o | output | 1 | All slots occupied, allocation refused |
| bcast_valid_i | input | 1 | Result broadcast valid |
| bcast_tag_i | input | TAG_W | Tag of the broadcast result |
| bcast_data_i | input | DATA_W | Broadcast result value |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_op_o | output | OP_W | Operation of the issuing instruction |
| issue_src0_o | output | DATA_W | Operand 0 value |
| issue_src1_o | output | DATA_W | Operand 1 value |

## Verification
The hardest case to reach from the ports is one where allocation age and slot
index disagree while several instructions wake up together. Only then does an
oldest-first selector behave differently from a lowest-index one. The stimulus
sets this up in steps:
- It fills three slots with instructions waiting on two different tags.
- It wakes the middle one alone, so that slot issues and is freed.
- It allocates a new instruction into that lower-numbered slot, now the youngest.
- It sends one broadcast that wakes three instructions at once.

The bench then checks that they issue in allocation order. Separate sequences
check these cases:
- capture during the allocation cycle;
- a refused allocation while full, exposed by draining the buffer;
- a flush that hits an instruction already presenting on the issue port.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned OP_W   = 4;
  parameter int unsigned TAG_W  = 4;
  parameter int unsigned DATA_W = 16;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } opnd_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    opnd_t           src0;
    opnd_t           src1;
  } slot_t;

  // Tag compare and value capture for one operand
  function automatic opnd_t snoop(opnd_t o, logic bv, logic [TAG_W-1:0] bt,
                                  logic [DATA_W-1:0] bd);
    opnd_t r;
    r = o;
    if (!o.rdy && bv && (o.tag == bt)) begin
      r.rdy = 1'b1;
      r.val = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic [NUM_ENTRIES-1:0] valid_i,
  output logic [NUM_ENTRIES-1:0] free_oh_o
);
  always_comb begin
    logic found;
    found     = 1'b0;
    free_oh_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        free_oh_o[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned AGE_W       = 2
) (
  input  logic [NUM_ENTRIES-1:0]            req_i,
  input  logic [NUM_ENTRIES-1:0][AGE_W-1:0] age_i,
  output logic [NUM_ENTRIES-1:0]            grant_o,
  output logic                              grant_any_o
);
  // Ages of occupied slots are unique, so a strict compare never ties
  always_comb begin
    logic [AGE_W-1:0] best_age;
    best_age    = '0;
    grant_o     = '0;
    grant_any_o = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (req_i[i] && (!grant_any_o || (age_i[i] < best_age))) begin
        grant_o     = '0;
        grant_o[i]  = 1'b1;
        best_age    = age_i[i];
        grant_any_o = 1'b1;
      end
    end
  end

  // R5
  grant_onehot_chk: assert final ($onehot0(grant_o));
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int unsigned AGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_en_i,
  input  slot_t             alloc_slot_i,
  input  logic [AGE_W-1:0]  alloc_age_i,
  input  logic              bcast_valid_i,
  input  logic [TAG_W-1:0]  bcast_tag_i,
  input  logic [DATA_W-1:0] bcast_data_i,
  input  logic              grant_i,
  input  logic              grant_any_i,
  input  logic [AGE_W-1:0]  grant_age_i,
  output logic              valid_o,
  output logic              req_o,
  output logic [AGE_W-1:0]  age_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] src0_o,
  output logic [DATA_W-1:0] src1_o
);
  logic             valid_q;
  slot_t            slot_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      age_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (alloc_en_i) begin
      valid_q     <= 1'b1;
      slot_q.op   <= alloc_slot_i.op;
      slot_q.src0 <= snoop(alloc_slot_i.src0, bcast_valid_i, bcast_tag_i, bcast_data_i);
      slot_q.src1 <= snoop(alloc_slot_i.src1, bcast_valid_i, bcast_tag_i, bcast_data_i);
      age_q       <= alloc_age_i;
    end else begin
      if (grant_i) valid_q <= 1'b0;
      slot_q.src0 <= snoop(slot_q.src0, bcast_valid_i, bcast_tag_i, bcast_data_i);
      slot_q.src1 <= snoop(slot_q.src1, bcast_valid_i, bcast_tag_i, bcast_data_i);
      // Close the gap left by an older issuing entry
      if (valid_q && grant_any_i && !grant_i && (age_q > grant_age_i))
        age_q <= age_q - AGE_W'(1);
    end
  end

  assign valid_o = valid_q;
  assign req_o   = valid_q && slot_q.src0.rdy && slot_q.src1.rdy;
  assign age_o   = age_q;
  assign op_o    = slot_q.op;
  assign src0_o  = slot_q.src0.val;
  assign src1_o  = slot_q.src1.val;

  // R5
  grant_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> req_o);

  // R2
  wake_by_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q) && !$past(req_o) && req_o) |-> $past(bcast_valid_i));

  // R7
  freed_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !flush_i) |=> !req_o || $past(alloc_en_i) || !$past(valid_q));
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  input  logic [OP_W-1:0]   alloc_op_i,
  input  logic              alloc_src0_rdy_i,
  input  logic [TAG_W-1:0]  alloc_src0_tag_i,
  input  logic [DATA_W-1:0] alloc_src0_data_i,
  input  logic              alloc_src1_rdy_i,
  input  logic [TAG_W-1:0]  alloc_src1_tag_i,
  input  logic [DATA_W-1:0] alloc_src1_data_i,
  output logic              full_o,
  input  logic              bcast_valid_i,
  input  logic [TAG_W-1:0]  bcast_tag_i,
  input  logic [DATA_W-1:0] bcast_data_i,
  output logic              issue_valid_o,
  output logic [OP_W-1:0]   issue_op_o,
  output logic [DATA_W-1:0] issue_src0_o,
  output logic [DATA_W-1:0] issue_src1_o
);
  localparam int unsigned AGE_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]             valid_vec, req_vec, free_oh, alloc_en;
  logic [NUM_ENTRIES-1:0]             grant_raw, grant_vec;
  logic [NUM_ENTRIES-1:0][AGE_W-1:0]  age_vec;
  logic [NUM_ENTRIES-1:0][OP_W-1:0]   op_vec;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] s0_vec, s1_vec;
  logic                               grant_any_raw, grant_any, alloc_go;
  logic [AGE_W-1:0]                   alloc_age, grant_age;
  slot_t                              alloc_slot;

  assign full_o    = &valid_vec;
  assign alloc_go  = alloc_valid_i && !full_o && !flush_i;
  assign alloc_en  = free_oh & {NUM_ENTRIES{alloc_go}};
  assign grant_any = grant_any_raw && !flush_i;
  assign grant_vec = grant_raw & {NUM_ENTRIES{!flush_i}};

  always_comb begin
    alloc_slot.op        = alloc_op_i;
    alloc_slot.src0.rdy  = alloc_src0_rdy_i;
    alloc_slot.src0.tag  = alloc_src0_tag_i;
    alloc_slot.src0.val  = alloc_src0_data_i;
    alloc_slot.src1.rdy  = alloc_src1_rdy_i;
    alloc_slot.src1.tag  = alloc_src1_tag_i;
    alloc_slot.src1.val  = alloc_src1_data_i;
  end

  // Newcomer age = number of entries that stay after this edge
  always_comb begin
    alloc_age = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      alloc_age = alloc_age + AGE_W'(valid_vec[i] && !grant_vec[i]);
  end

  always_comb begin
    grant_age    = '0;
    issue_op_o   = '0;
    issue_src0_o = '0;
    issue_src1_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grant_vec[i]) begin
        grant_age    = grant_age    | age_vec[i];
        issue_op_o   = issue_op_o   | op_vec[i];
        issue_src0_o = issue_src0_o | s0_vec[i];
        issue_src1_o = issue_src1_o | s1_vec[i];
      end
    end
  end
  assign issue_valid_o = grant_any;

  rs_free_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_free_pick (
    .valid_i  (valid_vec),
    .free_oh_o(free_oh)
  );

  rs_age_select #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) u_age_select (
    .req_i      (req_vec),
    .age_i      (age_vec),
    .grant_o    (grant_raw),
    .grant_any_o(grant_any_raw)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    rs_entry #(.AGE_W(AGE_W)) u_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flush_i      (flush_i),
      .alloc_en_i   (alloc_en[g]),
      .alloc_slot_i (alloc_slot),
      .alloc_age_i  (alloc_age),
      .bcast_valid_i(bcast_valid_i),
      .bcast_tag_i  (bcast_tag_i),
      .bcast_data_i (bcast_data_i),
      .grant_i      (grant_vec[g]),
      .grant_any_i  (grant_any),
      .grant_age_i  (grant_age),
      .valid_o      (valid_vec[g]),
      .req_o        (req_vec[g]),
      .age_o        (age_vec[g]),
      .op_o         (op_vec[g]),
      .src0_o       (s0_vec[g]),
      .src1_o       (s1_vec[g])
    );
  end

  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec == '0));

  // R8
  full_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && alloc_valid_i) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

  // R7
  issue_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && !alloc_valid_i) |=>
      ($countones(valid_vec) == $past($countones(valid_vec)) - 1));

  // R1
  reset_empty_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !issue_valid_o || rst_ni);
endmodule

// File: tb/rs_wakeup_select_bench.sv
module rs_wakeup_select_bench;
  import rs_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic              alloc_valid_i = 1'b0;
  logic [OP_W-1:0]   alloc_op_i = '0;
  logic              alloc_src0_rdy_i = 1'b0, alloc_src1_rdy_i = 1'b0;
  logic [TAG_W-1:0]  alloc_src0_tag_i = '0, alloc_src1_tag_i = '0;
  logic [DATA_W-1:0] alloc_src0_data_i = '0, alloc_src1_data_i = '0;
  logic              full_o;
  logic              bcast_valid_i = 1'b0;
  logic [TAG_W-1:0]  bcast_tag_i = '0;
  logic [DATA_W-1:0] bcast_data_i = '0;
  logic              issue_valid_o;
  logic [OP_W-1:0]   issue_op_o;
  logic [DATA_W-1:0] issue_src0_o, issue_src1_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rs_wakeup_select #(.NUM_ENTRIES(4)) u_rs_wakeup_select (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next();
    @(negedge clk_i);
    alloc_valid_i = 1'b0;
    bcast_valid_i = 1'b0;
    flush_i       = 1'b0;
  endtask

  task automatic alloc(input logic [OP_W-1:0] op, input logic r0,
                       input logic [TAG_W-1:0] t0, input logic [DATA_W-1:0] d0,
                       input logic r1, input logic [TAG_W-1:0] t1,
                       input logic [DATA_W-1:0] d1);
    alloc_valid_i     = 1'b1;
    alloc_op_i        = op;
    alloc_src0_rdy_i  = r0; alloc_src0_tag_i = t0; alloc_src0_data_i = d0;
    alloc_src1_rdy_i  = r1; alloc_src1_tag_i = t1; alloc_src1_data_i = d1;
  endtask

  task automatic bcast(input logic v, input logic [TAG_W-1:0] t,
                       input logic [DATA_W-1:0] d);
    bcast_valid_i = v; bcast_tag_i = t; bcast_data_i = d;
  endtask

  task automatic exp_none(input string req);
    #1 chk(issue_valid_o == 1'b0, req, 32'(issue_valid_o), 0);
  endtask

  task automatic exp_issue(input string req, input logic [OP_W-1:0] op,
                           input logic [DATA_W-1:0] s0, input logic [DATA_W-1:0] s1);
    #1;
    chk(issue_valid_o == 1'b1, req, 32'(issue_valid_o), 1);
    chk(issue_op_o == op, req, 32'(issue_op_o), 32'(op));
    chk(issue_src0_o == s0, req, 32'(issue_src0_o), 32'(s0));
    chk(issue_src1_o == s1, req, 32'(issue_src1_o), 32'(s1));
  endtask

  task automatic t_reset();
    #1;
    chk(full_o == 1'b0, "R1", 32'(full_o), 0);
    chk(issue_valid_o == 1'b0, "R1", 32'(issue_valid_o), 0);
  endtask

  task automatic t_ready_alloc();
    alloc(4'd1, 1, 0, 16'h00a1, 1, 0, 16'h00b2);
    exp_none("R3");
    next();
    exp_issue("R3", 4'd1, 16'h00a1, 16'h00b2);
    next();
    exp_none("R7");
    next();
  endtask

  task automatic t_wakeup();
    alloc(4'd2, 0, 4'd13, 16'h0, 1, 0, 16'h0022);
    next();
    exp_none("R2");
    bcast(1, 4'd12, 16'hdead);       // wrong tag
    exp_none("R2");
    next();
    bcast(0, 4'd13, 16'hbeef);       // invalid broadcast
    exp_none("R2");
    next();
    bcast(1, 4'd13, 16'h1234);
    exp_none("R4");
    next();
    exp_issue("R4", 4'd2, 16'h1234, 16'h0022);
    next();
    exp_none("R7");
    next();
  endtask

  task automatic t_alloc_capture();
    alloc(4'd3, 0, 4'd7, 16'h0, 0, 4'd7, 16'h0);
    bcast(1, 4'd7, 16'h0777);
    next();
    exp_issue("R6", 4'd3, 16'h0777, 16'h0777);
    next();
    exp_none("R6");
    next();
  endtask

  task automatic t_age_order();
    alloc(4'd4, 0, 4'd1, 0, 1, 0, 16'h0004); next();   // slot0
    alloc(4'd5, 0, 4'd2, 0, 1, 0, 16'h0005); next();   // slot1
    alloc(4'd6, 0, 4'd1, 0, 1, 0, 16'h0006); next();   // slot2
    bcast(1, 4'd2, 16'h2222); next();
    exp_issue("R5", 4'd5, 16'h2222, 16'h0005);
    next();
    alloc(4'd7, 0, 4'd1, 0, 1, 0, 16'h0007);           // reuses slot1, youngest
    next();
    bcast(1, 4'd1, 16'h1111);
    exp_none("R4");
    next();
    exp_issue("R5", 4'd4, 16'h1111, 16'h0004); next();
    exp_issue("R5", 4'd6, 16'h1111, 16'h0006); next();
    exp_issue("R5", 4'd7, 16'h1111, 16'h0007); next();
    exp_none("R7");
    next();
  endtask

  task automatic t_full();
    for (int k = 0; k < 4; k++) begin
      alloc(4'(8 + k), 0, 4'd9, 0, 1, 0, 16'(16'h0080 + k));
      #1 chk(full_o == 1'b0, "R8", 32'(full_o), 0);
      next();
    end
    #1 chk(full_o == 1'b1, "R8", 32'(full_o), 1);
    alloc(4'd15, 1, 0, 16'hffff, 1, 0, 16'hffff);      // must be refused
    next();
    exp_none("R8");
    bcast(1, 4'd9, 16'h0999);
    next();
    exp_issue("R8", 4'd8, 16'h0999, 16'h0080);
    next();
    chk(full_o == 1'b0, "R8", 32'(full_o), 0);
    for (int k = 1; k < 4; k++) begin
      exp_issue("R8", 4'(8 + k), 16'h0999, 16'(16'h0080 + k));
      next();
    end
    exp_none("R8");
    next();
  endtask

  task automatic t_flush();
    alloc(4'd13, 0, 4'd10, 0, 1, 0, 16'h00dd); next();
    alloc(4'd12, 1, 0, 16'h0c0c, 1, 0, 16'h0c0d); next();
    exp_issue("R9", 4'd12, 16'h0c0c, 16'h0c0d);
    flush_i = 1'b1;
    alloc(4'd14, 1, 0, 16'h0e0e, 1, 0, 16'h0e0e);     // dropped by flush
    exp_none("R9");
    next();
    bcast(1, 4'd10, 16'h0aaa);
    exp_none("R9");
    #1 chk(full_o == 1'b0, "R9", 32'(full_o), 0);
    next();
    exp_none("R9");
    next();
    exp_none("R9");
    next();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ready_alloc();
    t_wakeup();
    t_alloc_capture();
    t_age_order();
    t_full();
    t_flush();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule